// File: doc/BRIEF.md
# Variable-Page-Size Address Translation Buffer

The block is a small, fully associative buffer that turns a 32-bit virtual address into a 32-bit physical address. Every slot keeps its own page-size code, so one slot can cover 1 kB and its neighbour 1 MB. The size code sets how many upper address bits are compared with the slot's page number and then replaced by its frame number. Each slot also holds a 3-bit permission code, a dirty flag and a write-through flag. The lookup side is combinational. It returns the translated address, the cache-policy flag, a hit flag and a 2-bit fault code for the access type and privilege level that are presented.

Slots are filled through a load port. The load port writes the slot named by a 6-bit replacement pointer, which software can overwrite and which otherwise steps round-robin. When a lookup faults, a hardware-only register captures the virtual address on the next clock edge. Exception handlers can then read it. Page-table walking, caches and exception dispatch are handled outside this block.

Top module: `xlat_buffer`

## Requirements
- R1: A slot matches when it is valid and the virtual address agrees with its page number on the page-number bits. Size code 0 compares bits [31:10], code 1 compares [31:12], code 2 compares [31:16] and code 3 compares [31:20]. On a hit the physical address takes those bits from the slot's frame number. On a miss, `lk_paddr` and `lk_wthru` are zero.
- R2: Address bits below the page-number field pass unchanged from `lk_vaddr` to `lk_paddr`.
- R3: Permission codes 0 to 3 grant, in privileged mode (`lk_priv`=1), read / read+execute / read+write / read+write+execute in that order. Every unprivileged access to such a page faults with the protection code.
- R4: Permission codes 4 to 7 grant the same four right sets as codes 0 to 3, and they grant them to both privileged and unprivileged accesses.
- R5: A write access that hits a slot, passes the permission check and finds the dirty flag clear gets the first-write fault code.
- R6: `lk_wthru` shows the write-through flag of the slot that hit. 1 means write-through and 0 means write-back.
- R7: On the clock edge where `lk_valid` is high and the fault code is non-zero, `fault_addr` takes `lk_vaddr`. At every other edge it holds its value. Reset clears it to zero.
- R8: While `wr_en` is high, the slot indexed by `ptr_q` is loaded at the edge and the pointer steps by one, wrapping from ENTRIES-1 to 0. A pointer value of ENTRIES or more loads nothing and steps to 0. `ptr_we` loads `ptr_wdata` and overrides the step, while a load in the same cycle still uses the old pointer.
- R9: Fault encoding on `lk_fault`: 0 none, 1 miss, 2 protection, 3 first write. The priority is miss, then protection, then first write. The code is 0 whenever `lk_valid` is low.
- R10: Reset invalidates every slot and sets the pointer to 0. Loading a slot with `wr_valid`=0 invalidates it.
- R11: When several slots match, the one with the lowest index supplies the translation.
- R12: Access encoding on `lk_acc`: 0 read, 1 write, 2 execute. Value 3 is treated as read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access type |
| lk_priv | input | 1 | 1 = privileged access |
| lk_hit | output | 1 | A valid slot matches the address |
| lk_paddr | output | 32 | Translated physical address |
| lk_wthru | output | 1 | Cache policy of the hit page |
| lk_fault | output | 2 | Fault code |
| wr_en | input | 1 | Load the slot under the pointer |
| wr_vpn | input | 22 | Virtual page number, address bits [31:10] |
| wr_pfn | input | 22 | Frame number, address bits [31:10] |
| wr_size | input | 2 | Page-size code |
| wr_perm | input | 3 | Permission code |
| wr_dirty | input | 1 | Dirty flag |
| wr_wthru | input | 1 | Write-through flag |
| wr_valid | input | 1 | Valid flag of the loaded slot |
| ptr_we | input | 1 | Load the replacement pointer |
| ptr_wdata | input | 6 | New pointer value |
| ptr_q | output | 6 | Current replacement pointer |
| fault_addr | output | 32 | Address of the most recent faulting lookup |

## Verification
The hit flag, the physical address, the policy flag and the fault code are combinational. They are sampled 1 ns after the lookup inputs change at a falling edge, with no clock edge in between. The fault address, the pointer and slot contents change at the rising edge that follows their stimulus. The bench reads them at the next falling edge, and it reads slot contents through a later lookup. The sweep covers every size code, permission code, privilege level, access type and dirty state. Expected values come from shift-and-mask arithmetic done in the bench.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;

    localparam int VA_W   = 32;
    localparam int PTR_W  = 6;
    localparam int PN_LSB = 10;
    localparam int PN_W   = VA_W - PN_LSB;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_MISS    = 2'd1,
        FLT_PROT    = 2'd2,
        FLT_FIRSTWR = 2'd3
    } fault_e;

    typedef struct packed {
        logic            vld;
        logic [PN_W-1:0] vpn;
        logic [PN_W-1:0] pfn;
        logic [1:0]      sz;
        logic [2:0]      perm;
        logic            dirty;
        logic            wthru;
    } slot_t;

    // Mask of the page-number bits selected by a size code
    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
        logic [VA_W-1:0] m;
        case (sz)
            2'd0:    m = {{(VA_W-10){1'b1}}, 10'b0};
            2'd1:    m = {{(VA_W-12){1'b1}}, 12'b0};
            2'd2:    m = {{(VA_W-16){1'b1}}, 16'b0};
            default: m = {{(VA_W-20){1'b1}}, 20'b0};
        endcase
        return m;
    endfunction

    function automatic logic [VA_W-1:0] pn_to_addr(input logic [PN_W-1:0] pn);
        return {pn, {PN_LSB{1'b0}}};
    endfunction

    // Bit 2 opens the page to unprivileged code, bit 1 grants write, bit 0 execute
    function automatic logic perm_grants(input logic [2:0] perm,
                                         input logic       priv,
                                         input acc_e       acc);
        logic mode_ok;
        logic kind_ok;
        mode_ok = priv | perm[2];
        case (acc)
            ACC_WR:  kind_ok = perm[1];
            ACC_EX:  kind_ok = perm[0];
            default: kind_ok = 1'b1;
        endcase
        return mode_ok & kind_ok;
    endfunction

endpackage

// File: rtl/xlat_store.sv
`timescale 1ns/1ps
module xlat_store
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  slot_t                    wr_slot,
    input  logic                     ptr_we,
    input  logic [PTR_W-1:0]         ptr_wdata,
    output logic [PTR_W-1:0]         ptr_q,
    output slot_t [ENTRIES-1:0]      slots
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    logic [PTR_W-1:0] ptr_next;

    always_comb begin
        ptr_next = ptr_q;
        if (ptr_we) begin
            ptr_next = ptr_wdata;
        end else if (wr_en) begin
            ptr_next = (ptr_q >= LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_next;
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (wr_en && ptr_q == PTR_W'(i)) begin
                slots[i] <= wr_slot;
            end
        end
    end

endmodule

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
module xlat_match
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  slot_t [ENTRIES-1:0] slots,
    input  logic [VA_W-1:0]     vaddr,
    output logic                hit,
    output slot_t               hit_slot
);

    logic [ENTRIES-1:0] match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic [VA_W-1:0] diff;
        assign diff     = (vaddr ^ pn_to_addr(slots[i].vpn)) & page_mask(slots[i].sz);
        assign match[i] = slots[i].vld && (diff == '0);
    end

    // Scan downward so the lowest matching index is the last to assign
    always_comb begin
        hit      = |match;
        hit_slot = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_slot = slots[i];
        end
    end

endmodule

// File: rtl/xlat_judge.sv
`timescale 1ns/1ps
module xlat_judge
    import xlat_pkg::*;
(
    input  logic            lk_valid,
    input  logic [VA_W-1:0] vaddr,
    input  acc_e            acc,
    input  logic            priv,
    input  logic            hit,
    input  slot_t           slot,
    output logic [VA_W-1:0] paddr,
    output logic            wthru,
    output fault_e          fault
);

    logic [VA_W-1:0] mask;

    always_comb begin
        mask  = page_mask(slot.sz);
        paddr = '0;
        wthru = 1'b0;
        if (hit) begin
            paddr = (pn_to_addr(slot.pfn) & mask) | (vaddr & ~mask);
            wthru = slot.wthru;
        end
    end

    always_comb begin
        if (!lk_valid)                              fault = FLT_NONE;
        else if (!hit)                              fault = FLT_MISS;
        else if (!perm_grants(slot.perm, priv, acc)) fault = FLT_PROT;
        else if (acc == ACC_WR && !slot.dirty)      fault = FLT_FIRSTWR;
        else                                        fault = FLT_NONE;
    end

endmodule

// File: rtl/xlat_buffer.sv
`timescale 1ns/1ps
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lk_valid,
    input  logic [31:0] lk_vaddr,
    input  logic [1:0]  lk_acc,
    input  logic        lk_priv,
    output logic        lk_hit,
    output logic [31:0] lk_paddr,
    output logic        lk_wthru,
    output logic [1:0]  lk_fault,
    input  logic        wr_en,
    input  logic [21:0] wr_vpn,
    input  logic [21:0] wr_pfn,
    input  logic [1:0]  wr_size,
    input  logic [2:0]  wr_perm,
    input  logic        wr_dirty,
    input  logic        wr_wthru,
    input  logic        wr_valid,
    input  logic        ptr_we,
    input  logic [5:0]  ptr_wdata,
    output logic [5:0]  ptr_q,
    output logic [31:0] fault_addr
);

    slot_t               new_slot;
    slot_t [ENTRIES-1:0] slots;
    slot_t               hit_slot;
    fault_e              fault;

    always_comb begin
        new_slot.vld   = wr_valid;
        new_slot.vpn   = wr_vpn;
        new_slot.pfn   = wr_pfn;
        new_slot.sz    = wr_size;
        new_slot.perm  = wr_perm;
        new_slot.dirty = wr_dirty;
        new_slot.wthru = wr_wthru;
    end

    xlat_store #(.ENTRIES(ENTRIES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_slot   (new_slot),
        .ptr_we    (ptr_we),
        .ptr_wdata (ptr_wdata),
        .ptr_q     (ptr_q),
        .slots     (slots)
    );

    xlat_match #(.ENTRIES(ENTRIES)) u_match (
        .slots    (slots),
        .vaddr    (lk_vaddr),
        .hit      (lk_hit),
        .hit_slot (hit_slot)
    );

    xlat_judge u_judge (
        .lk_valid (lk_valid),
        .vaddr    (lk_vaddr),
        .acc      (acc_e'(lk_acc)),
        .priv     (lk_priv),
        .hit      (lk_hit),
        .slot     (hit_slot),
        .paddr    (lk_paddr),
        .wthru    (lk_wthru),
        .fault    (fault)
    );

    assign lk_fault = fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_addr <= '0;
        end else if (lk_valid && fault != FLT_NONE) begin
            fault_addr <= lk_vaddr;
        end
    end

endmodule

// File: rtl/xlat_buffer_sva.sv
`timescale 1ns/1ps
module xlat_buffer_sva #(
    parameter int ENTRIES = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        lk_valid,
    input logic [31:0] lk_vaddr,
    input logic [1:0]  lk_acc,
    input logic        lk_priv,
    input logic        lk_hit,
    input logic [31:0] lk_paddr,
    input logic        lk_wthru,
    input logic [1:0]  lk_fault,
    input logic        wr_en,
    input logic [21:0] wr_vpn,
    input logic [21:0] wr_pfn,
    input logic [1:0]  wr_size,
    input logic [2:0]  wr_perm,
    input logic        wr_dirty,
    input logic        wr_wthru,
    input logic        wr_valid,
    input logic        ptr_we,
    input logic [5:0]  ptr_wdata,
    input logic [5:0]  ptr_q,
    input logic [31:0] fault_addr
);

    localparam logic [5:0] LAST = 6'(ENTRIES - 1);

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_paddr[9:0] == lk_vaddr[9:0]);                          // R2

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_paddr == 32'd0 && !lk_wthru));                        // R1

    AST_MISS_CODE: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_hit) |-> lk_fault == 2'd1);                          // R9

    AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> lk_fault == 2'd0);                                      // R9

    AST_FAULT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_fault != 2'd0) |=> fault_addr == $past(lk_vaddr));    // R7

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(lk_valid && lk_fault != 2'd0) |=> $stable(fault_addr));             // R7

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ptr_we) |=>
            ptr_q == (($past(ptr_q) >= LAST) ? 6'd0 : $past(ptr_q) + 6'd1)); // R8

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        ptr_we |=> ptr_q == $past(ptr_wdata));                                // R8

endmodule

bind xlat_buffer xlat_buffer_sva #(.ENTRIES(ENTRIES)) u_sva (.*);

// File: tb/xlat_buffer_test.sv
`timescale 1ns/1ps
module xlat_buffer_test;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_priv = 1'b0;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic        lk_wthru;
    logic [1:0]  lk_fault;
    logic        wr_en = 1'b0;
    logic [21:0] wr_vpn = '0;
    logic [21:0] wr_pfn = '0;
    logic [1:0]  wr_size = '0;
    logic [2:0]  wr_perm = '0;
    logic        wr_dirty = 1'b0;
    logic        wr_wthru = 1'b0;
    logic        wr_valid = 1'b0;
    logic        ptr_we = 1'b0;
    logic [5:0]  ptr_wdata = '0;
    logic [5:0]  ptr_q;
    logic [31:0] fault_addr;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_fa = '0;

    logic        s_hit;
    logic [31:0] s_pa;
    logic        s_wt;
    logic [1:0]  s_flt;
    logic [31:0] s_fa;

    xlat_buffer #(.ENTRIES(N)) uut (.*);

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_ptr(input logic [5:0] v);
        @(negedge clk);
        ptr_we = 1'b1; ptr_wdata = v;
        @(negedge clk);
        ptr_we = 1'b0;
    endtask

    task automatic load(input logic [31:0] vbase, input logic [31:0] pbase, input logic [1:0] sz,
                        input logic [2:0] perm, input logic d, input logic wt, input logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_vpn = vbase[31:10]; wr_pfn = pbase[31:10];
        wr_size = sz; wr_perm = perm; wr_dirty = d; wr_wthru = wt; wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [1:0] acc, input logic pv);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_acc = acc; lk_priv = pv;
        #1;
        s_hit = lk_hit; s_pa = lk_paddr; s_wt = lk_wthru; s_flt = lk_fault;
        @(negedge clk);
        s_fa = fault_addr;
        lk_valid = 1'b0;
    endtask

    function automatic logic [31:0] mask_of(input int sz);
        int lsb;
        lsb = (sz == 0) ? 10 : (sz == 1) ? 12 : (sz == 2) ? 16 : 20;
        return ~((32'd1 << lsb) - 32'd1);
    endfunction

    function automatic logic [1:0] exp_fault(input int perm, input int pv, input int acc, input int d);
        bit right;
        if (pv == 0 && perm < 4) return 2'd2;
        right = (acc == 1) ? ((perm % 4) >= 2) : (acc == 2) ? ((perm % 2) == 1) : 1'b1;
        if (!right) return 2'd2;
        if (acc == 1 && d == 0) return 2'd3;
        return 2'd0;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] m, vb, pb, va;
        logic [1:0]  ef;
        int k;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state: pointer zero, everything misses, R7 capture register zero
        check(ptr_q == 6'd0, "R10 reset pointer", 32'(ptr_q), 0);
        check(fault_addr == 0, "R7 reset fault_addr", fault_addr, 0);
        lookup(32'h0000_0000, 2'd0, 1'b1);
        check(!s_hit && s_flt == 2'd1, "R10 reset miss", {s_hit, s_flt}, 32'd1);
        exp_fa = 32'h0000_0000;

        // Sweep of size, permission, privilege, access type and dirty state
        k = 0;
        for (int sz = 0; sz < 4; sz++) begin
            for (int perm = 0; perm < 8; perm++) begin
                for (int d = 0; d < 2; d++) begin
                    m  = mask_of(sz);
                    vb = (32'h9E37_79B9 * (k + 1)) & m;
                    pb = (32'h5A5A_0000 ^ (32'h0101_0400 * k)) & m;
                    set_ptr(6'd0);
                    load(vb, pb, 2'(sz), 3'(perm), d[0], k[0], 1'b1);
                    for (int pv = 0; pv < 2; pv++) begin
                        for (int acc = 0; acc < 4; acc++) begin
                            va = vb | ((32'h3C6E_F372 * (acc + 3 * pv + 1)) & ~m);
                            lookup(va, 2'(acc), pv[0]);
                            ef = exp_fault(perm, pv, acc == 3 ? 0 : acc, d);
                            check(s_hit, "R1 hit in sweep", 32'(s_hit), 1);
                            check(s_pa == ((pb & m) | (va & ~m)), "R1 R2 translation", s_pa, (pb & m) | (va & ~m));
                            check(s_wt == k[0], "R6 cache policy", 32'(s_wt), 32'(k[0]));
                            if (perm < 4)
                                check(s_flt == ef, "R3 privileged-only codes", 32'(s_flt), 32'(ef));
                            else
                                check(s_flt == ef, "R4 shared codes", 32'(s_flt), 32'(ef));
                            if (acc == 1 && ef == 2'd3)
                                check(s_flt == 2'd3, "R5 first write", 32'(s_flt), 3);
                            if (acc == 3)
                                check(s_flt == exp_fault(perm, pv, 0, d), "R12 code 3 as read", 32'(s_flt), 32'(ef));
                            if (ef != 2'd0) exp_fa = va;
                            check(s_fa == exp_fa, "R7 fault address", s_fa, exp_fa);
                        end
                    end
                    k++;
                end
            end
        end

        // R9 idle request gives no fault and leaves the capture register alone
        @(negedge clk);
        lk_valid = 1'b0; lk_vaddr = 32'hFFFF_FFFF; #1;
        check(lk_fault == 2'd0, "R9 idle no fault", 32'(lk_fault), 0);
        @(negedge clk);
        check(fault_addr == exp_fa, "R7 hold when idle", fault_addr, exp_fa);

        // R1 page boundaries on a 4 kB page
        set_ptr(6'd0);
        load(32'h4000_3000, 32'h0007_7000, 2'd1, 3'd7, 1'b1, 1'b0, 1'b1);
        lookup(32'h4000_3FFF, 2'd1, 1'b0);
        check(s_hit && s_pa == 32'h0007_7FFF && s_flt == 2'd0, "R1 top of page", s_pa, 32'h0007_7FFF);
        lookup(32'h4000_4000, 2'd0, 1'b0);
        check(!s_hit && s_flt == 2'd1 && s_pa == 0, "R1 R9 just above page", {s_hit, s_flt}, 1);
        check(s_fa == 32'h4000_4000, "R7 miss captured", s_fa, 32'h4000_4000);
        lookup(32'h4000_2FFF, 2'd0, 1'b0);
        check(!s_hit, "R1 just below page", 32'(s_hit), 0);

        // R9 miss outranks protection: unprivileged to code 0 region off-page still miss
        lookup(32'h7000_0000, 2'd1, 1'b0);
        check(s_flt == 2'd1, "R9 miss priority", 32'(s_flt), 1);

        // R11 lowest index wins among overlapping slots
        set_ptr(6'd1);
        load(32'h8123_4400, 32'h1111_1000, 2'd0, 3'd7, 1'b1, 1'b0, 1'b1);
        load(32'h8120_0000, 32'h2220_0000, 2'd3, 3'd7, 1'b1, 1'b1, 1'b1);
        lookup(32'h8123_4567, 2'd0, 1'b1);
        check(s_pa == 32'h1111_1167 && !s_wt, "R11 lowest index", s_pa, 32'h1111_1167);
        // R10 invalidating slot 1 exposes slot 2
        set_ptr(6'd1);
        load(32'h8123_4400, 32'h1111_1000, 2'd0, 3'd7, 1'b1, 1'b0, 1'b0);
        lookup(32'h8123_4567, 2'd0, 1'b1);
        check(s_pa == 32'h2223_4567 && s_wt, "R10 invalidated slot", s_pa, 32'h2223_4567);

        // R8 pointer stepping and wrap at N-1
        set_ptr(6'd2);
        check(ptr_q == 6'd2, "R8 pointer load", 32'(ptr_q), 2);
        load(32'hA000_0000, 32'h0, 2'd0, 3'd4, 1'b1, 1'b0, 1'b1);
        check(ptr_q == 6'd3, "R8 step", 32'(ptr_q), 3);
        load(32'hB000_0000, 32'h0, 2'd0, 3'd4, 1'b1, 1'b0, 1'b1);
        check(ptr_q == 6'd0, "R8 wrap", 32'(ptr_q), 0);
        // Out-of-range pointer: nothing loaded, steps to 0
        set_ptr(6'd9);
        load(32'hC000_0000, 32'h0, 2'd0, 3'd4, 1'b1, 1'b0, 1'b1);
        check(ptr_q == 6'd0, "R8 out-of-range wrap", 32'(ptr_q), 0);
        lookup(32'hC000_0000, 2'd0, 1'b0);
        check(!s_hit, "R8 out-of-range no load", 32'(s_hit), 0);
        // Pointer load overrides the step; the load uses the old pointer (0)
        @(negedge clk);
        wr_en = 1'b1; wr_vpn = 22'h0D0000 >> 0; wr_pfn = 22'h000100; wr_size = 2'd0;
        wr_perm = 3'd4; wr_dirty = 1'b1; wr_wthru = 1'b0; wr_valid = 1'b1;
        ptr_we = 1'b1; ptr_wdata = 6'd3;
        @(negedge clk);
        wr_en = 1'b0; ptr_we = 1'b0;
        check(ptr_q == 6'd3, "R8 load overrides step", 32'(ptr_q), 3);
        lookup({22'h0D0000, 10'h055}, 2'd0, 1'b0);
        check(s_hit && s_pa == {22'h000100, 10'h055}, "R8 old pointer used", s_pa, {22'h000100, 10'h055});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule